// File: doc/BRIEF.md
# Infrared Pulse-Width Capture Receiver

This block watches the output of an infrared demodulator, removes short glitches, and measures how long each high and each low level lasts, counted in clock cycles. Every finished level becomes one 32-bit entry in a small receive queue. The top bit of an entry holds the level and the low bits hold the length. Software drains the queue through a show-ahead read port.

Capture arms in one of two ways. In automatic mode it waits for a chosen edge of the filtered input. In manual mode it waits for a software start strobe. A run-length threshold, tied to either the high or the low level, ends a frame. When the selected level lasts long enough, the block pushes the partial level and stops until capture is disabled. Eight sticky status flags cover queue and counter events plus raw edges. Each flag has a set-enable and an output mask, and the flags drive two interrupt lines: one for the main group and one for the edge pair.

Top module: `irc_receiver`

## Requirements
- R1: The filtered level follows the input only after the input has differed from it for more than `cfg_filt` consecutive cycles. A pulse of `cfg_filt` cycles or fewer produces no entry and no edge flag, and its cycles count toward the surrounding level.
- R2: When the filtered level changes during capture, the finished level is pushed. Bit 31 holds that level and bits CNT_W-1:0 hold the number of cycles it lasted. The bits in between are zero.
- R3: In automatic mode (`cfg_manual`=0), capture arms on the edge chosen by `cfg_edge`: 0 is falling, 1 is rising, and 2 or 3 is either. The first entry is the level that the arming edge starts. Nothing is pushed before that edge.
- R4: In manual mode (`cfg_manual`=1), nothing is pushed until a one-cycle `man_start` strobe. After the strobe, capture proceeds as in R2.
- R5: `cfg_thr_lvl` selects the level that the threshold watches (1 = high). When a run of that level reaches `cfg_thr` cycles (at least 1), status bit 4 sets and the entry {level, `cfg_thr`} is pushed. Capture then stays stopped until `run_en` is dropped.
- R6: With the queue full, a push is handled by `cfg_ovw`. With 0 the new entry is discarded. With 1 the oldest entry is dropped and the new one is kept. Either case sets status bit 2.
- R7: Reading while the queue is empty leaves it empty and sets status bit 5.
- R8: When the duration counter passes its all-ones value, status bit 3 sets and the count wraps. The stored duration is then the length modulo 2^CNT_W.
- R9: Status bit 0 sets while the queue is full. Status bit 1 sets while the queue holds at least `fifo_thr` entries.
- R10: Every filtered rising edge sets status bit 6 and every filtered falling edge sets status bit 7, whether or not capture is running. These two bits drive only `irq_edge`. Bits 5:0 drive only `irq_main`.
- R11: A status bit sets only when its `int_en` bit is 1. A status bit stays set until a cycle with its `int_clr` bit high; when set and clear coincide, the set wins. Each interrupt line is the OR of its status bits whose `int_mask` bit is 0.
- R12: After reset, the queue is empty, all status bits are 0 and both interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_in | input | 1 | Raw demodulated infrared input |
| run_en | input | 1 | Capture enable; low returns to idle |
| cfg_manual | input | 1 | 1 = start on strobe, 0 = start on edge |
| cfg_edge | input | 2 | Arming edge: 0 falling, 1 rising, 2/3 either |
| man_start | input | 1 | Manual start strobe |
| cfg_filt | input | FILT_W | Glitch filter length in cycles |
| cfg_thr_lvl | input | 1 | Level watched by the run threshold |
| cfg_thr | input | CNT_W | Run-length threshold in cycles |
| cfg_ovw | input | 1 | Full policy: 1 overwrite oldest, 0 drop newest |
| fifo_thr | input | $clog2(DEPTH)+1 | Queue level for status bit 1 |
| rd_en | input | 1 | Pop the head entry |
| rd_data | output | 32 | Head entry (show-ahead) |
| fifo_cnt | output | $clog2(DEPTH)+1 | Entries held |
| int_en | input | 8 | Per-flag set enable |
| int_mask | input | 8 | Per-flag output mask |
| int_clr | input | 8 | Per-flag write-one clear |
| int_status | output | 8 | Sticky status flags |
| irq_main | output | 1 | Queue, counter and read-error interrupt |
| irq_edge | output | 1 | Rising/falling edge interrupt |

## Verification
The hardest case to reach is the counter wrap. With 31-bit durations, no bench can hold a level long enough. The bench therefore builds the receiver with a 10-bit counter and holds one level for 1100 cycles, while the threshold watches the other level. The overflow flag and the stored remainder of 76 are then both visible at the ports. The filter boundary is hit with pulses exactly `cfg_filt` and `cfg_filt`+1 cycles long. The two full-queue policies are reached by pushing ten levels into an eight-entry queue without reading.

// File: rtl/irc_pkg.sv
package irc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ARM  = 3'd1,
    ST_WAIT = 3'd2,
    ST_RUN  = 3'd3,
    ST_STOP = 3'd4
  } cap_st_e;

  localparam int NFLAG    = 8;
  localparam int F_FULL   = 0;
  localparam int F_LEVEL  = 1;
  localparam int F_OVF    = 2;
  localparam int F_WRAP   = 3;
  localparam int F_THR    = 4;
  localparam int F_RDERR  = 5;
  localparam int F_RISE   = 6;
  localparam int F_FALL   = 7;
  localparam int MAIN_TOP = 5;
endpackage

// File: rtl/irc_filter.sv
module irc_filter #(
  parameter int FILT_W   = 8,
  parameter bit IDLE_LVL = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              din,
  input  logic [FILT_W-1:0] cfg_filt,
  output logic              lvl,
  output logic              chg
);
  logic [1:0]        sync_q;
  logic [FILT_W-1:0] gcnt_q, gcnt_d;
  logic              lvl_q, lvl_d, chg_d;
  logic              differ;

  always_comb begin
    differ = (sync_q[1] != lvl_q);
    chg_d  = differ && (gcnt_q >= cfg_filt);
    lvl_d  = chg_d ? sync_q[1] : lvl_q;
    gcnt_d = (!differ || chg_d) ? '0 : gcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {2{IDLE_LVL}};
      gcnt_q <= '0;
      lvl_q  <= IDLE_LVL;
      chg    <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], din};
      gcnt_q <= gcnt_d;
      lvl_q  <= lvl_d;
      chg    <= chg_d;
    end
  end

  assign lvl = lvl_q;

  // R1: the filtered level never moves without a change pulse
  a_r1_level_moves_with_chg: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl_q) |-> chg);
  // R1: a change pulse always marks a new level
  a_r1_chg_is_new_level: assert property (@(posedge clk) disable iff (!rst_n)
    chg |-> (lvl_q != $past(lvl_q)));
endmodule

// File: rtl/irc_capture.sv
module irc_capture
  import irc_pkg::*;
#(
  parameter int CNT_W = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             cfg_manual,
  input  logic [1:0]       cfg_edge,
  input  logic             man_start,
  input  logic             lvl,
  input  logic             chg,
  input  logic             cfg_thr_lvl,
  input  logic [CNT_W-1:0] cfg_thr,
  output logic             push,
  output logic [31:0]      push_data,
  output logic             wrap,
  output logic             thr_hit
);
  cap_st_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, push_cnt;
  logic             push_lvl, trig;

  always_comb begin
    trig     = chg && (cfg_edge[1] || (cfg_edge[0] ? lvl : !lvl));
    st_d     = st_q;
    cnt_d    = cnt_q;
    push     = 1'b0;
    push_lvl = !lvl;
    push_cnt = cnt_q;
    wrap     = 1'b0;
    thr_hit  = 1'b0;
    if (!run_en) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: st_d = cfg_manual ? ST_WAIT : ST_ARM;
        ST_ARM: if (trig) begin
          st_d  = ST_RUN;
          cnt_d = CNT_W'(1);
        end
        ST_WAIT: if (man_start) begin
          st_d  = ST_RUN;
          cnt_d = CNT_W'(1);
        end
        ST_RUN: begin
          if (chg) begin
            push  = 1'b1;
            cnt_d = CNT_W'(1);
          end else if ((lvl == cfg_thr_lvl) && (cnt_q >= cfg_thr)) begin
            push     = 1'b1;
            push_lvl = lvl;
            thr_hit  = 1'b1;
            st_d     = ST_STOP;
          end else begin
            cnt_d = cnt_q + 1'b1;
            wrap  = &cnt_q;
          end
        end
        ST_STOP: st_d = ST_STOP;
        default: st_d = ST_IDLE;
      endcase
    end
    push_data            = '0;
    push_data[31]        = push_lvl;
    push_data[CNT_W-1:0] = push_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  // R3 / R4 / R5: entries only leave an active capture
  a_r3_push_only_running: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (st_q == ST_RUN));
  // R5: a threshold hit ends capture
  a_r5_stop_after_thr: assert property (@(posedge clk) disable iff (!rst_n)
    thr_hit |=> (st_q == ST_STOP) || !run_en);
  // R8: the counter restarts from zero after a wrap
  a_r8_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == '0));
endmodule

// File: rtl/irc_fifo.sv
module irc_fifo #(
  parameter int DEPTH = 8,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  input  logic          ovw,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] cnt,
  output logic          full,
  output logic          ovf,
  output logic          rderr
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          empty, do_pop, do_wr, rd_adv;

  always_comb begin
    full   = (cnt_q == CW'(DEPTH));
    empty  = (cnt_q == '0);
    do_pop = pop && !empty;
    rderr  = pop && empty;
    ovf    = push && full && !do_pop;
    do_wr  = push && (!full || do_pop || ovw);
    rd_adv = do_pop || (ovf && ovw);
    wp_d   = wp_q;
    rp_d   = rp_q;
    if (do_wr)  wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (rd_adv) rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    cnt_d = cnt_q + CW'(do_wr) - CW'(rd_adv);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp_q] <= wdata;
  end

  assign rdata = mem[rp_q];
  assign cnt   = cnt_q;

  // R6: the occupancy never exceeds the depth
  a_r6_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  // R6: a push into a full queue without a read leaves it full
  a_r6_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> full);
  // R7: a read from an empty queue changes nothing
  a_r7_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> (cnt_q == '0));
endmodule

// File: rtl/irc_receiver.sv
module irc_receiver
  import irc_pkg::*;
#(
  parameter int CNT_W  = 31,
  parameter int FILT_W = 8,
  parameter int DEPTH  = 8,
  localparam int CW    = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ir_in,
  input  logic              run_en,
  input  logic              cfg_manual,
  input  logic [1:0]        cfg_edge,
  input  logic              man_start,
  input  logic [FILT_W-1:0] cfg_filt,
  input  logic              cfg_thr_lvl,
  input  logic [CNT_W-1:0]  cfg_thr,
  input  logic              cfg_ovw,
  input  logic [CW-1:0]     fifo_thr,
  input  logic              rd_en,
  output logic [31:0]       rd_data,
  output logic [CW-1:0]     fifo_cnt,
  input  logic [NFLAG-1:0]  int_en,
  input  logic [NFLAG-1:0]  int_mask,
  input  logic [NFLAG-1:0]  int_clr,
  output logic [NFLAG-1:0]  int_status,
  output logic              irq_main,
  output logic              irq_edge
);
  logic             lvl, chg, push, wrap, thr_hit, full, ovf, rderr;
  logic [31:0]      push_data;
  logic [NFLAG-1:0] set_vec, stat_q, stat_d, live;

  irc_filter #(.FILT_W(FILT_W), .IDLE_LVL(1'b1)) u_filt (
    .clk(clk), .rst_n(rst_n), .din(ir_in), .cfg_filt(cfg_filt),
    .lvl(lvl), .chg(chg)
  );

  irc_capture #(.CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .cfg_manual(cfg_manual),
    .cfg_edge(cfg_edge), .man_start(man_start), .lvl(lvl), .chg(chg),
    .cfg_thr_lvl(cfg_thr_lvl), .cfg_thr(cfg_thr), .push(push),
    .push_data(push_data), .wrap(wrap), .thr_hit(thr_hit)
  );

  irc_fifo #(.DEPTH(DEPTH), .DW(32)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .wdata(push_data),
    .pop(rd_en), .ovw(cfg_ovw), .rdata(rd_data), .cnt(fifo_cnt),
    .full(full), .ovf(ovf), .rderr(rderr)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[F_FULL]  = full;
    set_vec[F_LEVEL] = (fifo_cnt >= fifo_thr);
    set_vec[F_OVF]   = ovf;
    set_vec[F_WRAP]  = wrap;
    set_vec[F_THR]   = thr_hit;
    set_vec[F_RDERR] = rderr;
    set_vec[F_RISE]  = chg && lvl;
    set_vec[F_FALL]  = chg && !lvl;
    stat_d = (stat_q & ~int_clr) | (set_vec & int_en);
    live   = stat_q & ~int_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign int_status = stat_q;
  assign irq_main   = |live[MAIN_TOP:0];
  assign irq_edge   = |live[NFLAG-1:MAIN_TOP+1];

  // R7: the read-error flag only rises after a read of an empty queue
  a_r7_rderr_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[F_RDERR]) |-> $past(rd_en && (fifo_cnt == '0)));

  for (genvar i = 0; i < NFLAG; i++) begin : g_sticky
    // R11: a flag holds until its clear bit is written
    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[i] && !int_clr[i]) |=> stat_q[i]);
    // R11: a flag cannot rise while its enable is off
    a_r11_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_q[i] && !int_en[i]) |=> !stat_q[i]);
  end
endmodule

// File: tb/irc_receiver_bench.sv
`timescale 1ns/1ps
module irc_receiver_bench;
  localparam int CNT_W = 10;
  localparam int FILT_W = 4;
  localparam int DEPTH = 8;
  localparam int CW = $clog2(DEPTH) + 1;
  localparam int F = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic ir_in, run_en, cfg_manual, man_start, cfg_thr_lvl, cfg_ovw, rd_en;
  logic [1:0] cfg_edge;
  logic [FILT_W-1:0] cfg_filt;
  logic [CNT_W-1:0] cfg_thr;
  logic [CW-1:0] fifo_thr, fifo_cnt;
  logic [31:0] rd_data;
  logic [7:0] int_en, int_mask, int_clr, int_status;
  logic irq_main, irq_edge;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irc_receiver #(.CNT_W(CNT_W), .FILT_W(FILT_W), .DEPTH(DEPTH)) u_irc_receiver (
    .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .run_en(run_en),
    .cfg_manual(cfg_manual), .cfg_edge(cfg_edge), .man_start(man_start),
    .cfg_filt(cfg_filt), .cfg_thr_lvl(cfg_thr_lvl), .cfg_thr(cfg_thr),
    .cfg_ovw(cfg_ovw), .fifo_thr(fifo_thr), .rd_en(rd_en), .rd_data(rd_data),
    .fifo_cnt(fifo_cnt), .int_en(int_en), .int_mask(int_mask),
    .int_clr(int_clr), .int_status(int_status), .irq_main(irq_main),
    .irq_edge(irq_edge)
  );

  function automatic logic [31:0] ent(input logic l, input int n);
    logic [31:0] e;
    e = '0;
    e[31] = l;
    e[CNT_W-1:0] = CNT_W'(n);
    return e;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input logic l, input int n);
    ir_in = l;
    tick(n);
  endtask

  task automatic pop_chk(input string req, input logic [31:0] exp);
    chk(req, rd_data, exp);
    rd_en = 1'b1;
    tick(1);
    rd_en = 1'b0;
  endtask

  task automatic drain();
    while (fifo_cnt != 0) begin
      rd_en = 1'b1;
      tick(1);
    end
    rd_en = 1'b0;
  endtask

  task automatic clr_all();
    int_clr = 8'hFF;
    tick(1);
    int_clr = 8'h00;
  endtask

  task automatic restart();
    run_en = 1'b0;
    tick(2);
    drain();
    ir_in = 1'b1;
    tick(20);
    clr_all();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int a, b, c;
    logic [31:0] exp_q [10];
    void'($urandom(32'd4242));
    rst_n = 1'b0; ir_in = 1'b1; run_en = 1'b0; cfg_manual = 1'b0;
    cfg_edge = 2'd0; man_start = 1'b0; cfg_filt = FILT_W'(F);
    cfg_thr_lvl = 1'b0; cfg_thr = '1; cfg_ovw = 1'b0; fifo_thr = CW'(4);
    rd_en = 1'b0; int_en = 8'hFF; int_mask = 8'h00; int_clr = 8'h00;
    #5;
    // R12: reset state
    chk("R12 cnt", 32'(fifo_cnt), 0);
    chk("R12 status", 32'(int_status), 0);
    chk("R12 irq", {30'd0, irq_main, irq_edge}, 0);
    tick(5);
    rst_n = 1'b1;
    tick(5);
    chk("R12 cnt after release", 32'(fifo_cnt), 0);

    // R2 / R3: falling-edge arming with random level lengths
    for (int it = 0; it < 3; it++) begin
      a = 8 + int'($urandom % 50); b = 8 + int'($urandom % 50); c = 8 + int'($urandom % 50);
      cfg_edge = 2'd0; run_en = 1'b1; tick(8);
      drive(1'b0, a); drive(1'b0, 0); drive(1'b1, b); drive(1'b0, c); drive(1'b1, 20);
      chk("R2 count", 32'(fifo_cnt), 3);
      pop_chk("R2 low", ent(1'b0, a));
      pop_chk("R2 high", ent(1'b1, b));
      pop_chk("R3 falling arm", ent(1'b0, c));
      restart();
    end

    // R3: rising-edge arming skips the low that precedes it
    cfg_edge = 2'd1; drive(1'b0, 20); run_en = 1'b1; tick(8);
    a = 12 + int'($urandom % 40); b = 12 + int'($urandom % 40);
    drive(1'b1, a); drive(1'b0, b); drive(1'b1, 20);
    chk("R3 rising count", 32'(fifo_cnt), 2);
    pop_chk("R3 rising first", ent(1'b1, a));
    pop_chk("R3 rising second", ent(1'b0, b));
    restart();

    // R3: either edge
    cfg_edge = 2'd2; run_en = 1'b1; tick(8);
    drive(1'b0, 17); drive(1'b1, 23); drive(1'b0, 20);
    chk("R3 both count", 32'(fifo_cnt), 2);
    pop_chk("R3 both first", ent(1'b0, 17));
    pop_chk("R3 both second", ent(1'b1, 23));
    restart();

    // R1: a pulse of cfg_filt cycles is swallowed
    cfg_edge = 2'd0; run_en = 1'b1; tick(8);
    drive(1'b0, 20); drive(1'b1, F); drive(1'b0, 10);
    chk("R1 no rise flag", 32'(int_status[6]), 0);
    drive(1'b0, 10); drive(1'b1, 20);
    chk("R1 glitch count", 32'(fifo_cnt), 1);
    pop_chk("R1 merged level", ent(1'b0, 20 + F + 20));

    // R10: edge flags feed only the edge line
    int_mask = 8'h3F; tick(1);
    chk("R10 rise flag", 32'(int_status[6]), 1);
    chk("R10 fall flag", 32'(int_status[7]), 1);
    chk("R10 lines", {30'd0, irq_main, irq_edge}, 1);
    int_mask = 8'hC0; int_clr = 8'h3F; tick(1); int_clr = 8'h00;
    chk("R10 edge masked", {30'd0, irq_main, irq_edge}, 0);
    // R11: clear one flag, the other stays
    int_clr = 8'h40; tick(1); int_clr = 8'h00;
    chk("R11 w1c", 32'(int_status[7:6]), 2);
    int_mask = 8'h00;
    restart();

    // R1: a pulse of cfg_filt+1 cycles is kept
    run_en = 1'b1; tick(8);
    drive(1'b0, 20); drive(1'b1, F + 1); drive(1'b0, 20); drive(1'b1, 20);
    chk("R1 pulse count", 32'(fifo_cnt), 3);
    pop_chk("R1 before", ent(1'b0, 20));
    pop_chk("R1 short kept", ent(1'b1, F + 1));
    pop_chk("R1 after", ent(1'b0, 20));
    restart();

    // R11 / R7: enable gating, then empty read
    int_en[5] = 1'b0; rd_en = 1'b1; tick(1); rd_en = 1'b0;
    chk("R11 gated", 32'(int_status[5]), 0);
    int_en[5] = 1'b1; rd_en = 1'b1; tick(1); rd_en = 1'b0;
    chk("R7 rderr", 32'(int_status[5]), 1);
    chk("R7 still empty", 32'(fifo_cnt), 0);
    chk("R11 irq main", 32'(irq_main), 1);
    int_mask = 8'h20; tick(1);
    chk("R11 masked", 32'(irq_main), 0);
    int_mask = 8'h00;
    clr_all();

    // R5: threshold on the high level stops capture
    cfg_thr_lvl = 1'b1; cfg_thr = CNT_W'(30); run_en = 1'b1; tick(8);
    drive(1'b0, 25); drive(1'b1, 60); drive(1'b0, 20); drive(1'b1, 20);
    chk("R5 flag", 32'(int_status[4]), 1);
    chk("R5 count", 32'(fifo_cnt), 2);
    pop_chk("R5 low", ent(1'b0, 25));
    pop_chk("R5 partial", ent(1'b1, 30));
    cfg_thr_lvl = 1'b0; cfg_thr = '1;
    restart();

    // R8: counter wrap on a long high
    cfg_edge = 2'd1; drive(1'b0, 20); run_en = 1'b1; tick(8);
    chk("R8 clear before", 32'(int_status[3]), 0);
    drive(1'b1, 1100); drive(1'b0, 15); drive(1'b1, 20);
    chk("R8 flag", 32'(int_status[3]), 1);
    pop_chk("R8 wrapped", ent(1'b1, 1100 % (1 << CNT_W)));
    pop_chk("R8 next", ent(1'b0, 15));
    restart();

    // R6 / R9: full queue with both policies
    for (int pol = 0; pol < 2; pol++) begin
      cfg_edge = 2'd0; cfg_ovw = pol[0]; run_en = 1'b1; tick(8);
      for (int i = 0; i < 10; i++) begin
        exp_q[i] = ent(i[0], 10 + i);
        drive(i[0], 10 + i);
      end
      drive(1'b0, 20);
      chk("R6 count", 32'(fifo_cnt), DEPTH);
      chk("R6 ovf flag", 32'(int_status[2]), 1);
      chk("R9 full flag", 32'(int_status[0]), 1);
      chk("R9 level flag", 32'(int_status[1]), 1);
      for (int i = 0; i < DEPTH; i++)
        pop_chk(pol == 0 ? "R6 drop newest" : "R6 drop oldest", exp_q[i + 2 * pol]);
      restart();
    end
    cfg_ovw = 1'b0;

    // R9: level flag stays low below the threshold
    run_en = 1'b1; tick(8);
    drive(1'b0, 15); drive(1'b1, 15); drive(1'b0, 20);
    chk("R9 below level", 32'(int_status[1]), 0);
    restart();

    // R4: manual start
    cfg_manual = 1'b1; run_en = 1'b1; tick(8);
    drive(1'b0, 20); drive(1'b1, 20);
    chk("R4 nothing before strobe", 32'(fifo_cnt), 0);
    man_start = 1'b1; tick(1); man_start = 1'b0;
    drive(1'b1, 5); drive(1'b0, 30); drive(1'b1, 25); drive(1'b0, 20);
    chk("R4 count", 32'(fifo_cnt), 3);
    chk("R4 partial level", 32'(rd_data[31]), 1);
    rd_en = 1'b1; tick(1); rd_en = 1'b0;
    pop_chk("R4 low", ent(1'b0, 30));
    pop_chk("R4 high", ent(1'b1, 25));
    cfg_manual = 1'b0;
    restart();

    done = 1;
    summary();
    $finish;
  end
endmodule